// File: doc/BRIEF.md
# I2C Bus Fault and Arbitration Monitor

This block sits beside an I2C controller/target engine and watches the two bus wires together with the value the local engine is putting on SDA. It finds START and STOP conditions. It counts completed SCL pulses in frames of nine, which is one byte plus its acknowledge. From these it raises two kinds of fault: a bus error when a START or STOP lands inside a frame, and an arbitration loss when the engine releases SDA high but the bus reads low on an SCL rising edge. Data shifting is not part of this block.

The engine tells the block its role (controller or target) and its transfer phase (idle, address, data, acknowledge). Faults are qualified by these inputs. The block then issues the reactions the engine must carry out. Any START seen as a target sends the engine back to address recognition. A controller that loses arbitration is told to clear its start request and fall back to target mode. In either role an arbitration loss asks for both lines to be released until the bus is freed by a STOP. Each fault sets a sticky flag that software clears with its own strobe. A single error interrupt combines the two flags behind an enable bit.

Top module: `i2c_fault_monitor`

## Requirements
- R1: A START is an SDA falling edge while SCL is high, and a STOP is an SDA rising edge while SCL is high. SDA changes while SCL is low are neither, and they cause no address-recognition restart.
- R2: The completed-pulse counter is cleared by every START, including a repeated START. The SCL falling edge that ends the START itself is not counted. The counter then counts SCL falling edges modulo nine, so a frame of 9 or 18 pulses ends on a boundary.
- R3: A START or STOP that arrives when the pulse count is not zero sets the bus-error flag, provided the block is involved in the transfer.
- R4: Phase encoding is 00 idle, 01 address, 10 data and 11 acknowledge. The block counts as involved when it is a controller in any phase other than idle, or a target in the data or acknowledge phase. A misplaced condition seen by a target in the address phase does not set the bus-error flag.
- R5: In target mode (ctrl_mode_i = 0), every START raises tgt_rescan_o for exactly one cycle, whether or not the START was misplaced.
- R6: A controller loses arbitration in the address, data or acknowledge phase when it drives SDA high (sda_drv_i = 1), yet SDA is sampled low on an SCL rising edge. On a loss, the arbitration flag is set and clr_start_o and to_target_o each pulse for one cycle.
- R7: A target checks arbitration only in the data and acknowledge phases, and a loss there does not pulse to_target_o. In either role, line_release_o rises on a loss and stays high until the next STOP.
- R8: err_irq_o is high exactly when err_ie_i is high and at least one fault flag is set.
- R9: Each fault flag stays set until its own clear strobe. Clearing one flag leaves the other untouched, and a new fault in the same cycle as a clear leaves the flag set.
- R10: No arbitration loss is flagged while the block drives SDA low, or while the sampled SDA matches the driven high value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line as seen on the pad |
| sda_i | input | 1 | SDA line as seen on the pad |
| sda_drv_i | input | 1 | Local SDA output value (1 = released high, 0 = pulled low) |
| ctrl_mode_i | input | 1 | 1 = controller role, 0 = target role |
| phase_i | input | 2 | Transfer phase: 00 idle, 01 address, 10 data, 11 acknowledge |
| err_ie_i | input | 1 | Error interrupt enable |
| clr_berr_i | input | 1 | Clear strobe for the bus-error flag |
| clr_arlo_i | input | 1 | Clear strobe for the arbitration-loss flag |
| berr_o | output | 1 | Sticky bus-error flag |
| arlo_o | output | 1 | Sticky arbitration-loss flag |
| err_irq_o | output | 1 | Gated error interrupt |
| line_release_o | output | 1 | Request to release SCL and SDA |
| clr_start_o | output | 1 | One-cycle pulse: clear the controller start request |
| to_target_o | output | 1 | One-cycle pulse: switch the engine to target mode |
| tgt_rescan_o | output | 1 | One-cycle pulse: target re-enters address recognition |

## Verification
A pulse counter that is out of step only shows up at the ports when the next START or STOP arrives. At that point berr_o either rises or stays low, three clock cycles after the SDA edge reaches the pad, so every frame in the tests ends on a condition. A wrong role or phase qualification shows up in the same cycle window, as a bus-error or arbitration flag that should not be set, or as a missing clr_start_o, to_target_o or tgt_rescan_o pulse. A line_release_o that is not dropped shows up at the first STOP after a loss.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_ADDR = 2'b01,
    PH_DATA = 2'b10,
    PH_ACK  = 2'b11
  } phase_e;

  // Next value of a counter that wraps after lim steps.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  // Bus errors count only while the block takes part in the transfer.
  function automatic logic berr_eligible(input logic is_ctrl, input phase_e ph);
    if (is_ctrl) return ph != PH_IDLE;
    return (ph == PH_DATA) || (ph == PH_ACK);
  endfunction

  // Arbitration is checked in a narrower window for a target.
  function automatic logic arb_eligible(input logic is_ctrl, input phase_e ph);
    if (is_ctrl) return ph != PH_IDLE;
    return (ph == PH_DATA) || (ph == PH_ACK);
  endfunction

endpackage

// File: rtl/i2cmon_line_sampler.sv
module i2cmon_line_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_pin,
  input  logic sda_pin,
  input  logic drv_in,
  output logic scl_q,
  output logic sda_q,
  output logic drv_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_sh, sda_sh, drv_sh;
  logic scl_prev, sda_prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
          drv_sh <= '1;
        end else begin
          scl_sh <= scl_pin;
          sda_sh <= sda_pin;
          drv_sh <= drv_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
          drv_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[STAGES-2:0], scl_pin};
          sda_sh <= {sda_sh[STAGES-2:0], sda_pin};
          drv_sh <= {drv_sh[STAGES-2:0], drv_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_sh[STAGES-1];
      sda_prev <= sda_sh[STAGES-1];
    end
  end

  assign scl_q    = scl_sh[STAGES-1];
  assign sda_q    = sda_sh[STAGES-1];
  assign drv_q    = drv_sh[STAGES-1];
  assign scl_rise = scl_q & ~scl_prev;
  assign scl_fall = ~scl_q & scl_prev;
  assign start_ev = scl_q & scl_prev & sda_prev & ~sda_q;
  assign stop_ev  = scl_q & scl_prev & ~sda_prev & sda_q;
endmodule

// File: rtl/i2cmon_pulse_counter.sv
module i2cmon_pulse_counter
  import i2cmon_pkg::*;
#(
  parameter int FRAME_PULSES = 9,
  parameter int CW = $clog2(FRAME_PULSES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_ev,
  input  logic          scl_fall,
  output logic [CW-1:0] count,
  output logic          at_boundary
);
  logic skip_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= '0;
      skip_fall <= 1'b0;
    end else if (start_ev) begin
      count     <= '0;
      skip_fall <= 1'b1;
    end else if (scl_fall) begin
      if (skip_fall) skip_fall <= 1'b0;
      else count <= CW'(wrap_inc(32'(count), FRAME_PULSES));
    end
  end

  assign at_boundary = (count == '0);
endmodule

// File: rtl/i2cmon_fault_flags.sv
module i2cmon_fault_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_berr,
  input  logic set_arlo,
  input  logic clr_berr,
  input  logic clr_arlo,
  output logic berr,
  output logic arlo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      berr <= 1'b0;
      arlo <= 1'b0;
    end else begin
      berr <= set_berr | (berr & ~clr_berr);
      arlo <= set_arlo | (arlo & ~clr_arlo);
    end
  end
endmodule

// File: rtl/i2c_fault_monitor.sv
module i2c_fault_monitor
  import i2cmon_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int FRAME_PULSES = 9,
  localparam int CW = $clog2(FRAME_PULSES)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       sda_drv_i,
  input  logic       ctrl_mode_i,
  input  logic [1:0] phase_i,
  input  logic       err_ie_i,
  input  logic       clr_berr_i,
  input  logic       clr_arlo_i,
  output logic       berr_o,
  output logic       arlo_o,
  output logic       err_irq_o,
  output logic       line_release_o,
  output logic       clr_start_o,
  output logic       to_target_o,
  output logic       tgt_rescan_o
);
  phase_e phase;
  assign phase = phase_e'(phase_i);

  // Named internal events, brought out for the checker.
  logic          scl_q, sda_q, drv_q;
  logic          scl_rise, scl_fall, ev_start, ev_stop;
  logic [CW-1:0] pulse_cnt;
  logic          at_boundary;
  logic          misplaced, berr_set, arb_loss;

  i2cmon_line_sampler #(.STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n),
    .scl_pin(scl_i), .sda_pin(sda_i), .drv_in(sda_drv_i),
    .scl_q(scl_q), .sda_q(sda_q), .drv_q(drv_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(ev_start), .stop_ev(ev_stop)
  );

  i2cmon_pulse_counter #(.FRAME_PULSES(FRAME_PULSES), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .start_ev(ev_start), .scl_fall(scl_fall),
    .count(pulse_cnt), .at_boundary(at_boundary)
  );

  assign misplaced = (ev_start | ev_stop) & ~at_boundary;
  assign berr_set  = misplaced & berr_eligible(ctrl_mode_i, phase);
  assign arb_loss  = scl_rise & drv_q & ~sda_q & arb_eligible(ctrl_mode_i, phase);

  i2cmon_fault_flags u_flg (
    .clk(clk), .rst_n(rst_n),
    .set_berr(berr_set), .set_arlo(arb_loss),
    .clr_berr(clr_berr_i), .clr_arlo(clr_arlo_i),
    .berr(berr_o), .arlo(arlo_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_release_o <= 1'b0;
      clr_start_o    <= 1'b0;
      to_target_o    <= 1'b0;
      tgt_rescan_o   <= 1'b0;
    end else begin
      if (arb_loss)     line_release_o <= 1'b1;
      else if (ev_stop) line_release_o <= 1'b0;
      clr_start_o  <= arb_loss & ctrl_mode_i;
      to_target_o  <= arb_loss & ctrl_mode_i;
      tgt_rescan_o <= ev_start & ~ctrl_mode_i;
    end
  end

  assign err_irq_o = err_ie_i & (berr_o | arlo_o);
endmodule

// File: rtl/i2cmon_checker.sv
module i2cmon_checker #(
  parameter int FRAME_PULSES = 9,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_mode_i,
  input logic [1:0]    phase_i,
  input logic          err_ie_i,
  input logic          clr_berr_i,
  input logic          clr_arlo_i,
  input logic          berr_o,
  input logic          arlo_o,
  input logic          err_irq_o,
  input logic          line_release_o,
  input logic          clr_start_o,
  input logic          to_target_o,
  input logic          ev_start,
  input logic          ev_stop,
  input logic [CW-1:0] pulse_cnt,
  input logic          arb_loss
);
  always @(posedge clk) begin
    if (rst_n) begin
      a_r2_count_range: assert (32'(pulse_cnt) < FRAME_PULSES);
    end
  end

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> pulse_cnt == '0);

  a_r3_berr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(berr_o) |-> $past((ev_start || ev_stop) && pulse_cnt != '0));

  a_r4_berr_involved: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(berr_o) |-> $past(ctrl_mode_i ? (phase_i != 2'b00) : phase_i[1]));

  a_r6_ctrl_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    to_target_o |-> clr_start_o && $past(ctrl_mode_i && arb_loss));

  a_r7_release_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
    arb_loss |=> line_release_o);

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !err_ie_i |-> !err_irq_o);

  a_r9_berr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    berr_o && !clr_berr_i |=> berr_o);

  a_r9_arlo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    arlo_o && !clr_arlo_i |=> arlo_o);

  a_r10_arlo_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arlo_o) |-> $past(arb_loss));
endmodule

bind i2c_fault_monitor i2cmon_checker #(.FRAME_PULSES(FRAME_PULSES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_mode_i(ctrl_mode_i), .phase_i(phase_i),
  .err_ie_i(err_ie_i), .clr_berr_i(clr_berr_i), .clr_arlo_i(clr_arlo_i),
  .berr_o(berr_o), .arlo_o(arlo_o), .err_irq_o(err_irq_o),
  .line_release_o(line_release_o), .clr_start_o(clr_start_o),
  .to_target_o(to_target_o), .ev_start(ev_start), .ev_stop(ev_stop),
  .pulse_cnt(pulse_cnt), .arb_loss(arb_loss)
);

// File: tb/sim_i2c_fault_monitor.sv
`timescale 1ns/1ps
module sim_i2c_fault_monitor;
  localparam real HALF = 2.0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, drv = 1'b1, ctrl = 1'b0;
  logic [1:0] phase = 2'b00;
  logic ie = 1'b0, cb = 1'b0, ca = 1'b0;
  logic berr, arlo, irq, rel, cstart, totgt, rescan;

  int checks = 0, fails = 0;
  int n_cstart = 0, n_totgt = 0, n_rescan = 0;

  always #(HALF) clk = ~clk;

  i2c_fault_monitor u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_drv_i(drv),
    .ctrl_mode_i(ctrl), .phase_i(phase), .err_ie_i(ie),
    .clr_berr_i(cb), .clr_arlo_i(ca),
    .berr_o(berr), .arlo_o(arlo), .err_irq_o(irq), .line_release_o(rel),
    .clr_start_o(cstart), .to_target_o(totgt), .tgt_rescan_o(rescan)
  );

  always @(negedge clk) begin
    if (cstart) n_cstart++;
    if (totgt)  n_totgt++;
    if (rescan) n_rescan++;
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda = 1'b1; hold(4); scl = 1'b1; hold(6);
    sda = 1'b0; hold(6); scl = 1'b0; hold(6);
  endtask

  task automatic bus_stop;
    scl = 1'b0; hold(2); sda = 1'b0; hold(4);
    scl = 1'b1; hold(6); sda = 1'b1; hold(8);
  endtask

  task automatic bus_bit(input logic v, input logic d);
    sda = v; drv = d; hold(4); scl = 1'b1; hold(6); scl = 1'b0; hold(4);
    drv = 1'b1;
  endtask

  task automatic bits(input int n);
    for (int i = 0; i < n; i++) bus_bit(1'b1, 1'b1);
  endtask

  task automatic clear_all;
    cb = 1'b1; ca = 1'b1; hold(1); cb = 1'b0; ca = 1'b0; hold(2);
  endtask

  task automatic t_reset;
    chk("R9 reset berr", berr, 0);
    chk("R9 reset arlo", arlo, 0);
    chk("R8 reset irq", irq, 0);
    chk("R7 reset release", rel, 0);
  endtask

  task automatic t_clean_frames;
    ctrl = 1'b1; phase = 2'b10;
    bus_start; bits(9); bus_stop;
    chk("R2 nine-pulse frame no berr", berr, 0);
    bus_start; bits(18); bus_stop;
    chk("R2 eighteen-pulse wrap no berr", berr, 0);
  endtask

  task automatic t_misplaced_stop;
    ie = 1'b1; ctrl = 1'b1; phase = 2'b10;
    bus_start; bits(4); bus_stop;
    chk("R3 misplaced STOP berr", berr, 1);
    chk("R8 irq with enable", irq, 1);
  endtask

  task automatic t_clear_independent;
    ca = 1'b1; hold(1); ca = 1'b0; hold(2);
    chk("R9 arlo clear keeps berr", berr, 1);
    cb = 1'b1; hold(1); cb = 1'b0; hold(2);
    chk("R9 berr cleared", berr, 0);
    chk("R8 irq drops", irq, 0);
  endtask

  task automatic t_target_addr;
    int r0;
    ctrl = 1'b0; phase = 2'b01; r0 = n_rescan;
    bus_start; bits(3); bus_start;
    chk("R4 target addr misplaced START no berr", berr, 0);
    chk("R5 two rescans", n_rescan - r0, 2);
    phase = 2'b10; bits(9); bus_stop;
    chk("R2 count cleared by repeated START", berr, 0);
  endtask

  task automatic t_low_toggles;
    int r0;
    ctrl = 1'b0; phase = 2'b01;
    bus_start; r0 = n_rescan;
    for (int i = 0; i < 3; i++) begin
      sda = 1'b1; hold(4); sda = 1'b0; hold(4);
    end
    chk("R1 SDA toggles with SCL low no START", n_rescan - r0, 0);
    bits(9); bus_stop;
    chk("R1 no condition from low toggles", berr, 0);
  endtask

  task automatic t_target_data_misplaced;
    int r0;
    ctrl = 1'b0; phase = 2'b10;
    bus_start; bits(2); r0 = n_rescan; bus_start;
    chk("R3 target data misplaced START berr", berr, 1);
    chk("R5 rescan on misplaced START", n_rescan - r0, 1);
    bits(9); bus_stop; clear_all;
  endtask

  task automatic t_irq_gate;
    ie = 1'b0; ctrl = 1'b1; phase = 2'b11;
    bus_start; bits(5); bus_stop;
    chk("R3 ack-phase misplaced STOP berr", berr, 1);
    chk("R8 irq gated off", irq, 0);
    clear_all;
  endtask

  task automatic t_ctrl_arb;
    int c0, t0;
    ie = 1'b1; ctrl = 1'b1; phase = 2'b01; c0 = n_cstart; t0 = n_totgt;
    bus_start; bus_bit(1'b0, 1'b1);
    chk("R6 controller arlo", arlo, 1);
    chk("R6 clr_start pulse", n_cstart - c0, 1);
    chk("R6 to_target pulse", n_totgt - t0, 1);
    chk("R7 release after loss", rel, 1);
    chk("R8 irq from arlo", irq, 1);
    bus_stop;
    chk("R7 release drops at STOP", rel, 0);
    chk("R9 arlo sticky past STOP", arlo, 1);
    clear_all;
    chk("R9 arlo cleared", arlo, 0);
  endtask

  task automatic t_tgt_arb;
    int t0;
    ctrl = 1'b0; phase = 2'b01; t0 = n_totgt;
    bus_start; bus_bit(1'b0, 1'b1);
    chk("R7 target addr phase no arlo", arlo, 0);
    phase = 2'b10; bus_bit(1'b0, 1'b1);
    chk("R7 target data arlo", arlo, 1);
    chk("R7 target no to_target", n_totgt - t0, 0);
    chk("R7 target release", rel, 1);
    bits(7); bus_stop; clear_all;
  endtask

  task automatic t_drive_low;
    ctrl = 1'b1; phase = 2'b10;
    bus_start; bus_bit(1'b0, 1'b0); bus_bit(1'b1, 1'b1);
    chk("R10 no arlo when driving low or matching", arlo, 0);
    bits(7); bus_stop;
    chk("R10 release stays low", rel, 0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(HALF * 2 * 200000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run;
  end

  initial begin
    hold(3); rst_n = 1'b1; hold(3);
    t_reset;
    t_clean_frames;
    t_misplaced_stop;
    t_clear_independent;
    t_target_addr;
    t_low_toggles;
    t_target_data_misplaced;
    t_irq_gate;
    t_ctrl_arb;
    t_tgt_arb;
    t_drive_low;
    finish_run;
  end
endmodule